// File: doc/BRIEF.md
# PCI Configuration Register File

This block holds the configuration space of a single PCI type-0 function as an array of byte registers, addressed by byte offset. Software (or an upstream transaction decoder) issues accesses of one to four bytes through a plain request port. Each request is accepted on the cycle it is presented, and its result (read data or an error flag) comes back on the next cycle. There is no back-pressure.

The first 64 bytes form the standard header. Within the header, a fixed per-byte mask decides which bits a write may change, and the upper status byte behaves as write-1-to-clear. Bytes from offset 0x40 up to the end of the space are plain storage and take written data unchanged. A side input lets device logic raise the error and event bits of the upper status byte. A parameter vector supplies the header's power-on contents.

The response path is a small state machine with three states. ST_IDLE means no request was seen on the previous cycle. ST_ACK means a legal request was accepted. ST_ERR means a rejected request was seen. Every cycle it moves on from any state: to ST_ACK when a legal request is present, to ST_ERR when an illegal request is present, and to ST_IDLE when no request is present. Reset forces ST_IDLE.

Top module: `pci_cfg_regfile`

## Requirements
- R1: A request with size 0, size above 4, or offset plus size above SPACE_BYTES is rejected. On the next cycle `rsp_valid` and `rsp_err` are 1 and `rsp_rdata` is 0, and no stored byte changes.
- R2: At offset 4 (command low byte) all eight bits are writable. At offset 5 only bits 2:0 are writable, and bits 7:3 keep their value.
- R3: Every header byte below 0x40 that is not named in R2, R4 or R6 is read-only: writes leave it unchanged. This includes offset 6, the low status byte.
- R4: At offset 7 (status high byte), writing a 1 to a bit in mask 0xF9 clears that bit. Writing a 0 leaves it unchanged. Bits 1 and 2 cannot be changed by writes.
- R5: A bit set in `status_set` that lies in mask 0xF9 sets the same bit of offset 7 at the next clock edge. When a set and a write-1-to-clear hit the same bit in the same cycle, the bit ends up set.
- R6: Offset 0x0C, offsets 0x10 to 0x27 and offset 0x3C are fully writable. Offsets 0x30, 0x31, 0x32 and 0x33 use write masks 0x01, 0xF8, 0xFF and 0xFF respectively.
- R7: Bytes at offset 0x40 and above store the written byte exactly.
- R8: After reset, header byte k holds byte k of HDR_DEFAULT (bits 8k+7:8k). The exception is offset 4, which has bits 2:0 (IO, memory and bus-master enables) cleared. Bytes at 0x40 and above read 0. No response is pending after reset.
- R9: A request at cycle N produces `rsp_valid`=1 at cycle N+1. For a legal read, lane i of `rsp_rdata` (bits 8i+7:8i) holds the byte at offset+i for i < size, and 0 otherwise. A legal write returns `rsp_rdata`=0. With no request, `rsp_valid` is 0 on the next cycle.
- R10: In a legal write, lane i (data bits 8i+7:8i, targeting offset+i) is applied only if i < size and `req_be[i]` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A request is present this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_offset | input | ADDR_W | Byte offset of lane 0 |
| req_size | input | 3 | Access size in bytes |
| req_be | input | 4 | Per-lane write enables |
| req_wdata | input | 32 | Write data, lane i targets offset+i |
| status_set | input | 8 | Event bits to set in the status high byte |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_err | output | 1 | Previous request was rejected |
| rsp_rdata | output | 32 | Read data, right-aligned to the offset |

## Verification
Every response is due exactly one clock after its request. A byte changed by a write, or by `status_set`, becomes visible to the first read presented after that edge. The bench drives inputs on the falling edge. Its behavioural model evaluates each rising edge in program order, with reads gathered before writes and a status set applied after a clear. The model's prediction is then compared with `rsp_valid`, `rsp_err` and `rsp_rdata` on the next falling edge, every cycle, including idle and reset cycles.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

    localparam int HDR_BYTES   = 64;
    localparam int HDR_BITS    = HDR_BYTES * 8;
    localparam int CMD_LO_IDX  = 4;
    localparam int STAT_HI_IDX = 7;
    localparam logic [7:0] CMD_ENABLE_BITS = 8'h07;
    localparam logic [7:0] STAT_HI_MASK    = 8'hF9;

    typedef enum logic [1:0] {
        CELL_RAW,
        CELL_MASKED,
        CELL_RW1C
    } cell_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACK,
        ST_ERR
    } rsp_state_e;

    // Writable-bit mask of a header byte
    function automatic logic [7:0] hdr_mask(int idx);
        logic [7:0] m;
        m = 8'h00;
        if (idx == CMD_LO_IDX || idx == 12 || idx == 60)
            m = 8'hFF;
        else if (idx == 5)
            m = 8'h07;
        else if (idx == STAT_HI_IDX)
            m = STAT_HI_MASK;
        else if (idx >= 16 && idx <= 39)
            m = 8'hFF;
        else if (idx == 48)
            m = 8'h01;
        else if (idx == 49)
            m = 8'hF8;
        else if (idx == 50 || idx == 51)
            m = 8'hFF;
        return m;
    endfunction

    // Default header image: a distinct value per byte
    function automatic logic [HDR_BITS-1:0] default_hdr();
        logic [HDR_BITS-1:0] v;
        v = '0;
        for (int k = 0; k < HDR_BYTES; k++)
            v[8*k +: 8] = 8'((k * 29 + 59) % 256);
        return v;
    endfunction

endpackage

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode
    import pci_cfg_pkg::*;
#(
    parameter int SPACE_BYTES = 256,
    localparam int ADDR_W = $clog2(SPACE_BYTES)
) (
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [2:0]        req_size,
    input  logic [3:0]        req_be,
    output logic              req_err,
    output logic [3:0]        lane_we
);

    logic bad_size;
    logic bad_range;

    always_comb begin
        bad_size  = (req_size == 3'd0) || (req_size > 3'd4);
        bad_range = (int'(req_offset) + int'(req_size)) > SPACE_BYTES;
        req_err   = req_valid && (bad_size || bad_range);
    end

    for (genvar i = 0; i < 4; i++) begin : g_lane
        assign lane_we[i] = req_valid && req_write && !req_err
                            && (3'(i) < req_size) && req_be[i];
    end

endmodule

// File: rtl/pci_cfg_cell.sv
module pci_cfg_cell
    import pci_cfg_pkg::*;
#(
    parameter cell_kind_e KIND    = CELL_MASKED,
    parameter logic [7:0] MASK    = 8'h00,
    parameter logic [7:0] RST_VAL = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] wdata,
    input  logic [7:0] set_bits,
    output logic [7:0] q
);

    logic [7:0] q_next;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= q_next;
    end

    if (KIND == CELL_RW1C) begin : g_rw1c
        logic [7:0] clr;
        always_comb begin
            clr    = we ? (wdata & MASK) : 8'h00;
            q_next = (q & ~clr) | (set_bits & MASK);
        end

        // R5: a raised event bit is present after the edge
        a_r5_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
            ((set_bits & MASK) != 8'h00) |=> ((q & $past(set_bits & MASK)) == $past(set_bits & MASK)));
        // R4: without an event no bit can go from 0 to 1
        a_r4_no_spurious_set: assert property (@(posedge clk) disable iff (!rst_n)
            (set_bits == 8'h00) |=> ((q & ~$past(q)) == 8'h00));
    end else if (KIND == CELL_MASKED) begin : g_masked
        logic [7:0] unused_set;
        assign unused_set = set_bits;
        always_comb q_next = we ? ((q & ~MASK) | (wdata & MASK)) : q;

        // R3: bits outside the mask never move
        a_r3_locked_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
            ((q & ~MASK) == ($past(q) & ~MASK)));
        // R2: without a write the byte holds
        a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !we |=> (q == $past(q)));
    end else begin : g_raw
        logic [7:0] unused_set;
        assign unused_set = set_bits;
        always_comb q_next = we ? wdata : q;

        // R7: raw bytes take the written value unchanged
        a_r7_raw_store: assert property (@(posedge clk) disable iff (!rst_n)
            we |=> (q == $past(wdata)));
    end

endmodule

// File: rtl/pci_cfg_regfile.sv
module pci_cfg_regfile
    import pci_cfg_pkg::*;
#(
    parameter int SPACE_BYTES = 256,
    parameter logic [HDR_BITS-1:0] HDR_DEFAULT = default_hdr(),
    localparam int ADDR_W = $clog2(SPACE_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_offset,
    input  logic [2:0]        req_size,
    input  logic [3:0]        req_be,
    input  logic [31:0]       req_wdata,
    input  logic [7:0]        status_set,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [31:0]       rsp_rdata
);

    logic        req_err;
    logic [3:0]  lane_we;
    logic [7:0]  cfg_q [SPACE_BYTES];
    logic [31:0] rd_word;
    logic [31:0] rdata_q;
    rsp_state_e  state_q, state_d;

    pci_cfg_decode #(.SPACE_BYTES(SPACE_BYTES)) u_decode (
        .req_valid  (req_valid),
        .req_write  (req_write),
        .req_offset (req_offset),
        .req_size   (req_size),
        .req_be     (req_be),
        .req_err    (req_err),
        .lane_we    (lane_we)
    );

    // Byte storage: header cells are masked, the rest are raw
    for (genvar k = 0; k < SPACE_BYTES; k++) begin : g_byte
        logic       we_k;
        logic [7:0] wd_k;

        always_comb begin
            we_k = 1'b0;
            wd_k = 8'h00;
            for (int i = 0; i < 4; i++) begin
                if (lane_we[i] && ((int'(req_offset) + i) == k)) begin
                    we_k = 1'b1;
                    wd_k = req_wdata[8*i +: 8];
                end
            end
        end

        if (k < HDR_BYTES) begin : g_hdr
            localparam logic [7:0] DEF_B = HDR_DEFAULT[8*k +: 8];
            localparam logic [7:0] RST_B = (k == CMD_LO_IDX) ? (DEF_B & ~CMD_ENABLE_BITS) : DEF_B;
            localparam cell_kind_e KIND_B = (k == STAT_HI_IDX) ? CELL_RW1C : CELL_MASKED;
            pci_cfg_cell #(.KIND(KIND_B), .MASK(hdr_mask(k)), .RST_VAL(RST_B)) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .we       (we_k),
                .wdata    (wd_k),
                .set_bits ((k == STAT_HI_IDX) ? status_set : 8'h00),
                .q        (cfg_q[k])
            );
        end else begin : g_ext
            pci_cfg_cell #(.KIND(CELL_RAW), .MASK(8'hFF), .RST_VAL(8'h00)) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .we       (we_k),
                .wdata    (wd_k),
                .set_bits (8'h00),
                .q        (cfg_q[k])
            );
        end
    end

    // Read gather, right-aligned to the request offset
    always_comb begin
        rd_word = 32'h0;
        for (int i = 0; i < 4; i++) begin
            if (3'(i) < req_size)
                rd_word[8*i +: 8] = cfg_q[ADDR_W'(int'(req_offset) + i)];
        end
    end

    // Next-state selection
    always_comb begin
        unique case (state_q)
            ST_IDLE, ST_ACK, ST_ERR: begin
                if (!req_valid)   state_d = ST_IDLE;
                else if (req_err) state_d = ST_ERR;
                else              state_d = ST_ACK;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Captured read data
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            rdata_q <= 32'h0;
        else if (req_valid && !req_write && !req_err)
            rdata_q <= rd_word;
        else
            rdata_q <= 32'h0;
    end

    // Outputs decoded from the state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_ACK:  rsp_valid = 1'b1;
            ST_ERR: begin
                rsp_valid = 1'b1;
                rsp_err   = 1'b1;
            end
            default: ;
        endcase
    end
    assign rsp_rdata = rdata_q;

    // R1: an illegal size is flagged on the next cycle
    a_r1_bad_size_err: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && (req_size == 3'd0 || req_size > 3'd4)) |=> (rsp_valid && rsp_err && rsp_rdata == 32'h0));
    // R9: every request gets exactly one response one cycle later
    a_r9_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    a_r9_no_stray_resp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R9: a write never returns data
    a_r9_write_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |=> (rsp_rdata == 32'h0));

endmodule

// File: tb/pci_cfg_regfile_tb.sv
`timescale 1ns/1ps
module pci_cfg_regfile_tb_top;

    localparam int SPACE = 256;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [7:0]  req_offset = 8'h0;
    logic [2:0]  req_size = 3'd0;
    logic [3:0]  req_be = 4'h0;
    logic [31:0] req_wdata = 32'h0;
    logic [7:0]  status_set = 8'h0;
    logic        rsp_valid, rsp_err;
    logic [31:0] rsp_rdata;

    int errors = 0;
    int checks = 0;
    string cur_tag = "R8";
    string exp_tag = "R8";
    bit    done = 1'b0;

    logic [7:0]  m [SPACE];
    logic        exp_valid = 1'b0, exp_err = 1'b0;
    logic [31:0] exp_rdata = 32'h0;

    always #2 clk = ~clk;

    pci_cfg_regfile dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_offset(req_offset), .req_size(req_size), .req_be(req_be),
        .req_wdata(req_wdata), .status_set(status_set),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
    );

    function automatic logic [7:0] wmask(int k);
        if (k == 4 || k == 12 || k == 60) return 8'hFF;
        if (k == 5) return 8'h07;
        if (k >= 16 && k <= 39) return 8'hFF;
        if (k == 48) return 8'h01;
        if (k == 49) return 8'hF8;
        if (k == 50 || k == 51) return 8'hFF;
        return 8'h00;
    endfunction

    function automatic logic [7:0] reset_byte(int k);
        logic [7:0] b;
        if (k >= 64) return 8'h00;
        b = 8'((k * 29 + 59) % 256);
        if (k == 4) b = b & 8'hF8;
        return b;
    endfunction

    // Reference model evaluated at every rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < SPACE; k++) m[k] = reset_byte(k);
            exp_valid = 1'b0; exp_err = 1'b0; exp_rdata = 32'h0;
            exp_tag = "R8";
        end else begin
            exp_tag = cur_tag;
            exp_valid = req_valid;
            exp_err = 1'b0;
            exp_rdata = 32'h0;
            if (req_valid) begin
                int sz, off;
                sz = int'(req_size);
                off = int'(req_offset);
                exp_err = (sz < 1) || (sz > 4) || (off + sz > SPACE);
                if (!exp_err && !req_write)
                    for (int i = 0; i < sz; i++) exp_rdata[8*i +: 8] = m[off + i];
                if (!exp_err && req_write)
                    for (int i = 0; i < sz; i++) begin
                        if (req_be[i]) begin
                            int k;
                            logic [7:0] d;
                            k = off + i;
                            d = req_wdata[8*i +: 8];
                            if (k >= 64)     m[k] = d;
                            else if (k == 7) m[7] = m[7] & ~(d & 8'hF9);
                            else             m[k] = (m[k] & ~wmask(k)) | (d & wmask(k));
                        end
                    end
            end
            m[7] = m[7] | (status_set & 8'hF9);
        end
    end

    // Compare every cycle on the falling edge
    always @(negedge clk) begin
        if (!done) begin
            checks++;
            if (rsp_valid !== exp_valid || rsp_err !== exp_err || rsp_rdata !== exp_rdata) begin
                errors++;
                $display("FAIL %s: valid/err/rdata got %0b/%0b/%08h expected %0b/%0b/%08h",
                         exp_tag, rsp_valid, rsp_err, rsp_rdata, exp_valid, exp_err, exp_rdata);
            end
        end
    end

    task automatic req(input bit wr, input int off, input int sz, input logic [3:0] be,
                       input logic [31:0] d, input string tag);
        @(negedge clk);
        cur_tag = tag;
        req_valid = 1'b1; req_write = wr; req_offset = 8'(off);
        req_size = 3'(sz); req_be = be; req_wdata = d;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            req_valid = 1'b0; req_write = 1'b0; status_set = 8'h00;
        end
    endtask

    task automatic read_all(input string tag);
        for (int a = 0; a < SPACE; a += 4) req(1'b0, a, 4, 4'h0, 32'h0, tag);
        idle(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            done = 1'b1;
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(2);
        read_all("R8");

        // R2: command bytes
        req(1'b1, 4, 2, 4'hF, 32'h0000FFFF, "R2");
        req(1'b0, 4, 2, 4'h0, 32'h0, "R2");
        req(1'b1, 4, 2, 4'hF, 32'h0000A25A, "R2");
        req(1'b0, 4, 4, 4'h0, 32'h0, "R2");
        idle(1);

        // R3 / R6: ones then zeros across the whole header
        for (int a = 0; a < 64; a += 4) req(1'b1, a, 4, 4'hF, 32'hFFFFFFFF, "R3");
        read_all("R3");
        for (int a = 0; a < 64; a += 4) req(1'b1, a, 4, 4'hF, 32'h00000000, "R6");
        read_all("R6");
        req(1'b1, 16'h30, 4, 4'hF, 32'h5A5A5A5A, "R6");
        req(1'b0, 16'h30, 4, 4'h0, 32'h0, "R6");
        req(1'b1, 12, 1, 4'hF, 32'h000000C3, "R6");
        req(1'b1, 60, 1, 4'hF, 32'h0000003C, "R6");
        req(1'b0, 12, 1, 4'h0, 32'h0, "R6");
        req(1'b0, 60, 1, 4'h0, 32'h0, "R6");
        idle(1);

        // R4 / R5: status high byte
        @(negedge clk); cur_tag = "R5"; req_valid = 1'b0; status_set = 8'hFF;
        idle(1);
        req(1'b0, 6, 2, 4'h0, 32'h0, "R5");
        req(1'b1, 7, 1, 4'hF, 32'h00000008, "R4");
        req(1'b0, 7, 1, 4'h0, 32'h0, "R4");
        req(1'b1, 7, 1, 4'hF, 32'h00000000, "R4");
        req(1'b0, 7, 1, 4'h0, 32'h0, "R4");
        req(1'b1, 4, 4, 4'hF, 32'hFF000000, "R4");
        req(1'b0, 4, 4, 4'h0, 32'h0, "R4");
        req(1'b1, 7, 1, 4'hF, 32'h00000080, "R5");
        status_set = 8'h80;
        idle(1);
        req(1'b0, 7, 1, 4'h0, 32'h0, "R5");
        idle(1);

        // R7: raw area
        req(1'b1, 64, 4, 4'hF, 32'hDEADBEEF, "R7");
        req(1'b1, 252, 4, 4'hF, 32'h01234567, "R7");
        req(1'b1, 131, 2, 4'hF, 32'h0000F00D, "R7");
        req(1'b0, 64, 4, 4'h0, 32'h0, "R7");
        req(1'b0, 252, 4, 4'h0, 32'h0, "R7");
        req(1'b0, 131, 2, 4'h0, 32'h0, "R7");
        idle(1);

        // R1: rejected requests
        req(1'b1, 64, 0, 4'hF, 32'h11111111, "R1");
        req(1'b1, 64, 5, 4'hF, 32'h22222222, "R1");
        req(1'b1, 254, 4, 4'hF, 32'h33333333, "R1");
        req(1'b0, 253, 4, 4'h0, 32'h0, "R1");
        req(1'b0, 7, 7, 4'h0, 32'h0, "R1");
        req(1'b0, 64, 4, 4'h0, 32'h0, "R1");
        req(1'b0, 252, 4, 4'h0, 32'h0, "R1");
        idle(1);

        // R10: lane enables
        req(1'b1, 80, 4, 4'b0101, 32'hAABBCCDD, "R10");
        req(1'b1, 20, 4, 4'b1010, 32'h99887766, "R10");
        req(1'b0, 80, 4, 4'h0, 32'h0, "R10");
        req(1'b0, 20, 4, 4'h0, 32'h0, "R10");
        idle(1);

        // R9: short and unaligned reads
        req(1'b0, 17, 1, 4'h0, 32'h0, "R9");
        req(1'b0, 81, 2, 4'h0, 32'h0, "R9");
        req(1'b0, 253, 3, 4'h0, 32'h0, "R9");
        req(1'b0, 5, 3, 4'h0, 32'h0, "R9");
        idle(2);

        // R9: mixed traffic
        for (int n = 0; n < 3000; n++) begin
            int off;
            off = ($urandom % 3 == 0) ? int'($urandom % 64) : int'($urandom % 256);
            req(1'($urandom), off, int'($urandom % 6), 4'($urandom), $urandom, "R9");
            status_set = ($urandom % 8 == 0) ? 8'($urandom) : 8'h00;
            if ($urandom % 5 == 0) idle(1);
        end
        idle(2);

        // R8: reset in the middle restores defaults and clears enables
        req(1'b1, 4, 1, 4'hF, 32'h000000FF, "R8");
        idle(1);
        @(negedge clk); rst_n = 1'b0; cur_tag = "R8";
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        idle(1);
        read_all("R8");
        idle(2);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule